// File: doc/BRIEF.md
# I2C Receive-Only Slave with Clock Stretching

This block is a receive-only slave on a two-wire I2C bus. It samples the clock and data lines of an external master into the system clock domain and recognises start and stop conditions. It collects the first byte after each start, compares it with a programmable 7-bit own address, and acknowledges on a match. It then goes on to accept data bytes and acknowledges every one of them.

After each acknowledged byte, whether address or data, the block loads the byte into a read register and raises a flag. It then pulls the bus clock low, beginning at the falling edge of the acknowledge clock. The clock stays held until the host pulses its read strobe. That pulse releases the clock and the next byte can begin. The host clears the flag with its own strobe. An interrupt output follows the flag only while interrupts are enabled.

Both bus outputs are pull-down enables for open-drain pads. A 1 on an output pulls its line low, and a 0 releases it. The block never drives a line high.

Top module: `i2c_rx_stretch`

## Requirements
- R1: After reset the line pull outputs, `busy`, `flag` and `irq` are all 0.
- R2: While `en` is 1, a start condition (SDA falls while SCL is high) sets `busy` to 1.
- R3: A stop condition (SDA rises while SCL is high) clears `busy`, releases both lines and returns the block to idle.
- R4: While `en` is 0, all bus activity is ignored: `busy` stays 0, no acknowledge is given and SCL is never held.
- R5: The first byte after a start arrives MSB first, as 7 address bits followed by the direction bit in bit 0. The block acknowledges it only when the 7 bits equal `own_addr` and bit 0 is 0. To acknowledge, it pulls SDA low from the SCL fall after the eighth bit until the SCL fall after the ninth clock.
- R6: On the rising edge of the ninth clock of each acknowledged byte, `flag` is set and `rx_data` is loaded with the byte. For the address byte this includes the direction bit in bit 0. `flag_clr` clears `flag`, and a set in the same cycle wins.
- R7: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1.
- R8: From the SCL fall after the ninth clock of an acknowledged byte, SCL is held low until a `data_rd` pulse. `flag_clr` does not release it. A `data_rd` pulse outside this hold has no effect.
- R9: Data bytes after an address match are received MSB first and each one is acknowledged.
- R10: After a non-matching address, the block gives no acknowledge, does not hold SCL and sets no flag, and it ignores all further bytes until the next start or stop.
- R11: A repeated start in any state, including part-way through a byte or after a mismatch, restarts address reception.
- R12: The block pulls SDA only during acknowledge slots. During data bits the line carries the master's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| own_addr | input | 7 | Slave address to match |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| data_rd | input | 1 | One-cycle strobe: host has read `rx_data` |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| rx_data | output | 8 | Last acknowledged byte |
| busy | output | 1 | Bus-busy status |
| flag | output | 1 | Byte-received flag |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the cycle-level rules. A start sets busy, and a stop idles the block and frees both lines. A disabled block stays quiet. SDA is pulled only in the acknowledge state. The clock hold lasts until a read, and the flag rises only on the ninth rising clock. A skipping slave touches neither line. The bench's directed bus transactions are needed to show the rest: address matching including the direction bit, the MSB-first byte values, acknowledge levels seen on the wired lines, interrupt gating, and recovery from a repeated start part-way through a byte or after a mismatch.

// File: rtl/i2c_rx_stretch_pkg.sv
package i2c_rx_stretch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK,
        ST_HOLD,
        ST_SKIP
    } srx_state_e;

endpackage

// File: rtl/srx_sync_cell.sv
module srx_sync_cell #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q_now,
    output logic q_prev
);

    typedef struct packed {
        logic [STAGES-1:0] ch;
        logic              prev;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d.ch   = {c_q.ch[STAGES-2:0], d};
        c_d.prev = c_q.ch[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ch: {STAGES{RST_VAL}}, prev: RST_VAL};
        else        c_q <= c_d;
    end

    assign q_now  = c_q.ch[STAGES-1];
    assign q_prev = c_q.prev;

endmodule

// File: rtl/srx_bus_events.sv
module srx_bus_events #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    localparam int NLINES = 2;
    localparam int IX_SCL = 1;
    localparam int IX_SDA = 0;

    logic [NLINES-1:0] raw, now, prev;

    assign raw = {scl_raw, sda_raw};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        srx_sync_cell #(.STAGES(STAGES), .RST_VAL(1'b1)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .d      (raw[i]),
            .q_now  (now[i]),
            .q_prev (prev[i])
        );
    end

    assign sda_lvl  = now[IX_SDA];
    assign scl_rise =  now[IX_SCL] & ~prev[IX_SCL];
    assign scl_fall = ~now[IX_SCL] &  prev[IX_SCL];
    // SDA edge while SCL stays high on both samples
    assign start_ev = now[IX_SCL] & prev[IX_SCL] &  prev[IX_SDA] & ~now[IX_SDA];
    assign stop_ev  = now[IX_SCL] & prev[IX_SCL] & ~prev[IX_SDA] &  now[IX_SDA];

endmodule

// File: rtl/srx_engine.sv
module srx_engine
    import i2c_rx_stretch_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              flag_clr,
    input  logic              data_rd,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    output logic [BYTE_W-1:0] rx_data,
    output logic              flag,
    output logic              busy,
    output logic              sda_pull,
    output logic              scl_pull
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        srx_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] dat;
        logic              flag;
        logic              busy;
        logic              sda_pull;
        logic              scl_pull;
    } eng_t;

    eng_t n_d, n_q;

    logic byte_full;
    logic addr_hit;

    assign byte_full = (n_q.cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (n_q.sh[BYTE_W-1 -: ADDR_W] == own_addr) && !n_q.sh[0];

    always_comb begin
        n_d = n_q;
        if (!en) begin
            n_d.st       = ST_IDLE;
            n_d.cnt      = '0;
            n_d.sh       = '0;
            n_d.flag     = 1'b0;
            n_d.busy     = 1'b0;
            n_d.sda_pull = 1'b0;
            n_d.scl_pull = 1'b0;
        end else begin
            if (flag_clr) n_d.flag = 1'b0;
            if (stop_ev) begin
                n_d.st       = ST_IDLE;
                n_d.cnt      = '0;
                n_d.busy     = 1'b0;
                n_d.sda_pull = 1'b0;
                n_d.scl_pull = 1'b0;
            end else if (start_ev) begin
                n_d.st       = ST_ADDR;
                n_d.cnt      = '0;
                n_d.sh       = '0;
                n_d.busy     = 1'b1;
                n_d.sda_pull = 1'b0;
                n_d.scl_pull = 1'b0;
            end else begin
                case (n_q.st)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && !byte_full) begin
                            n_d.sh  = {n_q.sh[BYTE_W-2:0], sda_lvl};
                            n_d.cnt = n_q.cnt + CNT_W'(1);
                        end else if (scl_fall && byte_full) begin
                            if (n_q.st == ST_DATA || addr_hit) begin
                                n_d.st       = ST_ACK;
                                n_d.sda_pull = 1'b1;
                            end else begin
                                n_d.st = ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_rise) begin
                            n_d.flag = 1'b1;
                            n_d.dat  = n_q.sh;
                        end else if (scl_fall) begin
                            n_d.sda_pull = 1'b0;
                            n_d.scl_pull = 1'b1;
                            n_d.st       = ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (data_rd) begin
                            n_d.scl_pull = 1'b0;
                            n_d.cnt      = '0;
                            n_d.st       = ST_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '{st: ST_IDLE, cnt: '0, sh: '0, dat: '0,
                     flag: 1'b0, busy: 1'b0, sda_pull: 1'b0, scl_pull: 1'b0};
        end else begin
            n_q <= n_d;
        end
    end

    assign rx_data  = n_q.dat;
    assign flag     = n_q.flag;
    assign busy     = n_q.busy;
    assign sda_pull = n_q.sda_pull;
    assign scl_pull = n_q.scl_pull;

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_ev) |=> n_q.busy);

    p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stop_ev) |=> (!n_q.busy && !n_q.sda_pull && !n_q.scl_pull && n_q.st == ST_IDLE));

    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!n_q.busy && !n_q.sda_pull && !n_q.scl_pull));

    p_flag_on_ninth_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(n_q.flag) |-> $past(n_q.st == ST_ACK && scl_rise));

    p_hold_until_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.scl_pull && en && !data_rd && !start_ev && !stop_ev) |=> n_q.scl_pull);

    p_skip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.st == ST_SKIP) |-> (!n_q.sda_pull && !n_q.scl_pull));

    p_ack_slot_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        n_q.sda_pull |-> (n_q.st == ST_ACK));

endmodule

// File: rtl/i2c_rx_stretch.sv
module i2c_rx_stretch #(
    parameter int ADDR_W      = 7,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              irq_en,
    input  logic              flag_clr,
    input  logic              data_rd,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              busy,
    output logic              flag,
    output logic              irq
);

    logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

    srx_bus_events #(.STAGES(SYNC_STAGES)) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    srx_engine #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .own_addr (own_addr),
        .flag_clr (flag_clr),
        .data_rd  (data_rd),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rx_data  (rx_data),
        .flag     (flag),
        .busy     (busy),
        .sda_pull (sda_pull),
        .scl_pull (scl_pull)
    );

    // R7: request only while enabled
    assign irq = flag & irq_en;

endmodule

// File: tb/sim_i2c_rx_stretch.sv
module sim_i2c_rx_stretch;

    localparam int CLK_PERIOD = 10;
    localparam int T          = 20;
    localparam int WD_LIMIT   = 150000;
    localparam logic [6:0] MY_ADDR = 7'h5A;
    localparam logic [7:0] ADDR_WR = {MY_ADDR, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic irq_en = 1'b0;
    logic flag_clr = 1'b0;
    logic data_rd = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic scl_pull, sda_pull, busy, flag, irq;
    logic [7:0] rx_data;
    logic scl_i, sda_i;

    int vecs = 0;
    int fails = 0;
    int stray = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_i = m_scl & ~scl_pull;
    assign sda_i = m_sda & ~sda_pull;

    i2c_rx_stretch u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .own_addr(MY_ADDR), .irq_en(irq_en),
        .flag_clr(flag_clr), .data_rd(data_rd), .scl_i(scl_i), .sda_i(sda_i),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .rx_data(rx_data),
        .busy(busy), .flag(flag), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            fails = fails + 1;
            $display("FAIL watchdog (all R) actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic raise_scl();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_i) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        m_sda = b;
        wt(T);
        raise_scl();
        wt(T/2);
        seen = sda_i;
        wt(T/2);
        m_scl = 1'b0;
        wt(T);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(v[i], s);
            if (s !== v[i]) stray++;
        end
        clk_bit(1'b1, ack);
    endtask

    task automatic do_start();
        m_sda = 1'b1;
        wt(T);
        raise_scl();
        wt(T);
        m_sda = 1'b0;
        wt(T);
        m_scl = 1'b0;
        wt(T);
    endtask

    task automatic do_stop();
        m_scl = 1'b0;
        m_sda = 1'b0;
        wt(T);
        raise_scl();
        wt(T);
        m_sda = 1'b1;
        wt(T);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_rd();
        data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; wt(2);
    endtask

    task automatic t_reset();
        chk("R1 scl_pull", scl_pull, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 busy", busy, 0);
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_disabled();
        logic a;
        en = 1'b0;
        do_start();
        chk("R4 busy while disabled", busy, 0);
        write_byte(ADDR_WR, a);
        chk("R4 no ack while disabled", a, 1);
        chk("R4 no stretch while disabled", scl_pull, 0);
        chk("R4 no flag while disabled", flag, 0);
        do_stop();
        en = 1'b1;
        wt(4);
    endtask

    task automatic t_basic();
        logic a;
        irq_en = 1'b0;
        stray = 0;
        do_start();
        chk("R2 busy after start", busy, 1);
        write_byte(ADDR_WR, a);
        chk("R5 address ack", a, 0);
        chk("R6 flag after address", flag, 1);
        chk("R6 rx_data address byte", rx_data, ADDR_WR);
        chk("R7 irq masked", irq, 0);
        chk("R8 scl held after ack", scl_pull, 1);
        wt(50);
        chk("R8 scl still held", scl_pull, 1);
        pulse_clr();
        chk("R6 flag cleared", flag, 0);
        chk("R8 clear does not release", scl_pull, 1);
        irq_en = 1'b1;
        pulse_rd();
        chk("R8 released by read", scl_pull, 0);
        write_byte(8'hA5, a);
        chk("R9 data ack A5", a, 0);
        chk("R9 rx_data A5", rx_data, 8'hA5);
        chk("R7 irq raised", irq, 1);
        chk("R8 held after data", scl_pull, 1);
        pulse_clr();
        chk("R7 irq follows flag", irq, 0);
        pulse_rd();
        write_byte(8'h3C, a);
        chk("R9 data ack 3C", a, 0);
        chk("R9 rx_data 3C", rx_data, 8'h3C);
        pulse_clr();
        pulse_rd();
        chk("R12 no sda pull in data bits", stray, 0);
        do_stop();
        chk("R3 busy cleared", busy, 0);
        chk("R3 scl released", scl_pull, 0);
        chk("R3 sda released", sda_pull, 0);
        data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; wt(4);
        chk("R8 stray read keeps data", rx_data, 8'h3C);
        chk("R8 stray read no clock change", scl_pull, 0);
        chk("R8 stray read no flag", flag, 0);
    endtask

    task automatic t_mismatch();
        logic a;
        do_start();
        write_byte({7'h11, 1'b0}, a);
        chk("R10 no ack wrong address", a, 1);
        chk("R10 no stretch wrong address", scl_pull, 0);
        chk("R10 no flag wrong address", flag, 0);
        write_byte(8'h00, a);
        chk("R10 later byte ignored", a, 1);
        chk("R10 later byte no flag", flag, 0);
        do_stop();
        do_start();
        write_byte({MY_ADDR, 1'b1}, a);
        chk("R5 read direction not acked", a, 1);
        chk("R5 read direction no stretch", scl_pull, 0);
        do_stop();
    endtask

    task automatic t_restart();
        logic a, s;
        do_start();
        write_byte(ADDR_WR, a);
        chk("R11 first address ack", a, 0);
        pulse_clr();
        pulse_rd();
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        do_start();
        write_byte(ADDR_WR, a);
        chk("R11 ack after mid-byte restart", a, 0);
        chk("R11 rx_data after restart", rx_data, ADDR_WR);
        pulse_clr();
        pulse_rd();
        do_stop();
        do_start();
        write_byte({7'h23, 1'b0}, a);
        chk("R11 mismatch before restart", a, 1);
        do_start();
        write_byte(ADDR_WR, a);
        chk("R11 ack after restart from skip", a, 0);
        chk("R11 flag after restart from skip", flag, 1);
        pulse_clr();
        pulse_rd();
        do_stop();
    endtask

    initial begin
        wt(5);
        t_reset();
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_disabled();
        t_basic();
        t_mismatch();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule